// File: doc/BRIEF.md
# Serial-Tuned Resampling Phase Accumulator

This block decides when the decimating filters downstream should take an output sample. It holds a 32-bit phase accumulator. Each accepted input sample adds a phase step to it, and every wrap past full scale marks a sample instant. Each sample instant leaves the block as one beat on a strobe stream, together with the five most significant phase bits at that moment. Those bits tell later stages how far past the ideal instant the strobe landed.

The phase step is the sum of two values:
- a fixed nominal rate, `rate_center`, held on plain control pins;
- a correction word that an external symbol-timing loop loads one bit at a time through a serial port.

A sync pulse moves a completed correction word into use. The accumulated phase is left alone when this happens, so timing corrections change the rate smoothly and never cause a phase jump. A control pin gates the correction on or off.

Input samples arrive on a valid/ready stream. Only the handshake matters; the block carries no sample data. The strobe output is also valid/ready:
- A strobe beat stays valid, with its phase held steady, until the consumer accepts it.
- While a beat waits, `smp_ready` is low, so the accumulator does not advance and no sample instant is lost.
- When nothing is pending, or the pending beat is taken in the same cycle, `smp_ready` is high.

Top module: `resamp_phase_nco`

## Requirements
- R1: After reset, `stb_valid` is 0, `smp_ready` is 1, the accumulator is zero and the stored correction word is zero.
- R2: Each accepted input sample (`smp_valid` and `smp_ready` both 1 at a rising edge) adds the phase step to the accumulator modulo 2^32. When that addition carries out of bit 31, a strobe beat is valid from the following cycle.
- R3: `stb_phase` of a strobe beat equals bits 31..27 of the accumulator value produced by the addition that carried.
- R4: The phase step is `rate_center + correction` (modulo 2^32) when `corr_en` is 1, and `rate_center` alone when `corr_en` is 0.
- R5: On every rising edge with `ser_sync` low, `ser_bit` is shifted into the serial holding register, most significant bit first. After 32 such edges, the first bit shifted in sits at bit 31 of the word.
- R6: A rising edge with `ser_sync` high copies the holding register into the correction word and shifts nothing. Samples accepted at that same edge still use the old correction; samples accepted from the next edge on use the new one. The accumulator value is unchanged by the load.
- R7: Edges without an accepted sample leave the accumulator unchanged and produce no new strobe beat.
- R8: While `stb_valid` is 1 and `stb_ready` is 0, `stb_valid` stays 1, `stb_phase` stays stable and `smp_ready` is 0. When `stb_valid` is 0, or `stb_ready` is 1, `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_center | input | 32 | Nominal phase step |
| corr_en | input | 1 | 1 adds the correction word to the step |
| ser_bit | input | 1 | Serial correction data, MSB first |
| ser_sync | input | 1 | Load pulse moving the holding register into the correction word |
| smp_valid | input | 1 | An input sample is offered |
| smp_ready | output | 1 | The block can accept a sample |
| stb_valid | output | 1 | A sample-instant strobe is offered |
| stb_ready | input | 1 | Consumer accepts the strobe |
| stb_phase | output | 5 | Top accumulator bits at the strobe |

## Verification
A corrupted accumulator does not show up as an error flag. It shows up in two ways at the ports: strobes arrive on the wrong sample count, and `stb_phase` values differ from a reference accumulator advanced with the same steps. Because every carry reveals five phase bits, a divergence normally shows at the next strobe, within 2^32 divided by the step in accepted samples. A wrong holding or correction register stays hidden until the first strobe after the sync that uses it. Lost back-pressure shows on the very next stalled cycle, as a dropped beat or a changed phase.

// File: rtl/resamp_nco_pkg.sv
package resamp_nco_pkg;
  localparam int unsigned ACC_W = 32;
  localparam int unsigned PH_W  = 5;
  typedef logic [ACC_W-1:0] phase_t;
  typedef logic [PH_W-1:0]  tap_t;
endpackage

// File: rtl/resamp_ser_corr.sv
module resamp_ser_corr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_bit,
  input  logic         ser_sync,
  output logic [W-1:0] corr_word
);
  logic [W-1:0] hold_q;
  logic [W-1:0] corr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      corr_q <= '0;
    end else if (ser_sync) begin
      corr_q <= hold_q;
    end else begin
      hold_q <= {hold_q[W-2:0], ser_bit};
    end
  end

  assign corr_word = corr_q;

  a_r5_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sync |=> hold_q[0] == $past(ser_bit));
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sync |=> corr_q == $past(hold_q));
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sync |=> $stable(corr_q));
endmodule

// File: rtl/resamp_phase_acc.sv
module resamp_phase_acc #(
  parameter int unsigned W    = 32,
  parameter int unsigned TAPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [W-1:0]    step,
  output logic            wrap,
  output logic [TAPW-1:0] wrap_tap
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, step};
  assign wrap     = adv & sum[W];
  assign wrap_tap = sum[W-1 -: TAPW];

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (adv) acc_q <= sum[W-1:0];
  end

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc_q));
  a_r2_wraps_only_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> adv);
endmodule

// File: rtl/resamp_stb_out.sv
module resamp_stb_out #(
  parameter int unsigned TAPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap,
  input  logic [TAPW-1:0] wrap_tap,
  input  logic            stb_ready,
  output logic            stb_valid,
  output logic [TAPW-1:0] stb_phase,
  output logic            room
);
  logic            v_q;
  logic [TAPW-1:0] ph_q;

  assign room = !v_q || stb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ph_q <= '0;
    end else if (wrap) begin
      v_q  <= 1'b1;
      ph_q <= wrap_tap;
    end else if (stb_ready) begin
      v_q  <= 1'b0;
    end
  end

  assign stb_valid = v_q;
  assign stb_phase = ph_q;

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && !stb_ready |=> v_q && $stable(ph_q));
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    v_q && !stb_ready |-> !wrap);
endmodule

// File: rtl/resamp_phase_nco.sv
module resamp_phase_nco
  import resamp_nco_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rate_center,
  input  logic        corr_en,
  input  logic        ser_bit,
  input  logic        ser_sync,
  input  logic        smp_valid,
  output logic        smp_ready,
  output logic        stb_valid,
  input  logic        stb_ready,
  output logic [4:0]  stb_phase
);
  phase_t corr_word;
  phase_t step;
  logic   adv;
  logic   wrap;
  tap_t   wrap_tap;
  logic   room;

  resamp_ser_corr #(.W(ACC_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_sync(ser_sync),
    .corr_word(corr_word)
  );

  assign step = rate_center + (corr_en ? corr_word : '0);
  assign adv  = smp_valid & room;

  resamp_phase_acc #(.W(ACC_W), .TAPW(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .step(step),
    .wrap(wrap), .wrap_tap(wrap_tap)
  );

  resamp_stb_out #(.TAPW(PH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .wrap_tap(wrap_tap),
    .stb_ready(stb_ready), .stb_valid(stb_valid), .stb_phase(stb_phase),
    .room(room)
  );

  assign smp_ready = room;

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stb_valid && !stb_ready |-> !smp_ready);
  a_r7_no_new_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && stb_ready |=> !stb_valid);
endmodule

// File: tb/resamp_phase_nco_tb_top.sv
module resamp_phase_nco_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rate_center = '0;
  logic        corr_en = 1'b0;
  logic        ser_bit = 1'b0;
  logic        ser_sync = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic        stb_valid;
  logic        stb_ready = 1'b1;
  logic [4:0]  stb_phase;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_acc, m_hold, m_corr;
  logic        m_valid;
  logic [4:0]  m_phase;

  always #4 clk = ~clk;

  resamp_phase_nco dut_i (
    .clk(clk), .rst_n(rst_n), .rate_center(rate_center), .corr_en(corr_en),
    .ser_bit(ser_bit), .ser_sync(ser_sync), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .stb_valid(stb_valid), .stb_ready(stb_ready),
    .stb_phase(stb_phase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict, compare at next negedge.
  task automatic cyc(input bit v, input bit rdy, input bit sd, input bit ss, input string req);
    logic [32:0] s;
    logic [31:0] st;
    bit exp_rdy, fire;
    smp_valid = v; stb_ready = rdy; ser_bit = sd; ser_sync = ss;
    #1;
    exp_rdy = !m_valid || rdy;
    chk({req, " R8 ready"}, {31'b0, smp_ready}, {31'b0, exp_rdy});
    fire = v && exp_rdy;
    st = rate_center + (corr_en ? m_corr : 32'h0);
    if (fire) begin
      s = {1'b0, m_acc} + {1'b0, st};
      m_acc = s[31:0];
      if (s[32]) begin m_valid = 1'b1; m_phase = s[31:27]; end
      else if (rdy) m_valid = 1'b0;
    end else if (rdy) m_valid = 1'b0;
    if (ss) m_corr = m_hold; else m_hold = {m_hold[30:0], sd};
    @(negedge clk);
    chk({req, " R2 valid"}, {31'b0, stb_valid}, {31'b0, m_valid});
    if (m_valid) chk({req, " R3 phase"}, {27'b0, stb_phase}, {27'b0, m_phase});
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic load_word(input logic [31:0] w, input bit stream, input string req);
    for (int i = 31; i >= 0; i--) cyc(stream, 1'b1, w[i], 1'b0, req);
    cyc(stream, 1'b1, 1'b0, 1'b1, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0; m_hold = 0; m_corr = 0; m_valid = 0; m_phase = 0;
    chk("R1 stb_valid", {31'b0, stb_valid}, 32'h0);
    chk("R1 smp_ready", {31'b0, smp_ready}, 32'h1);
  endtask

  task automatic t_plain;
    corr_en = 1'b0;
    rate_center = 32'h4000_0000;
    run(12, "R2 quarter");
    rate_center = 32'h3000_0001;
    run(20, "R3 uneven");
  endtask

  task automatic t_idle;
    int seen = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, "R7 idle");
      if (stb_valid) seen++;
    end
    chk("R7 no strobe while idle", seen, 0);
    run(6, "R7 resume");
  endtask

  task automatic t_serial;
    load_word(32'h1234_5678, 1'b0, "R5 load");
    corr_en = 1'b1;
    run(16, "R4 with corr");
    corr_en = 1'b0;
    run(8, "R4 corr off");
    corr_en = 1'b1;
    load_word(32'hF800_0000, 1'b1, "R6 live load");
    run(20, "R6 new corr");
  endtask

  task automatic t_backpressure;
    rate_center = 32'h8000_0000;
    corr_en = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R8 stall");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R8 release");
    for (int i = 0; i < 10; i++) cyc(1'b1, i[0], 1'b0, 1'b0, "R8 toggle");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_plain();
    t_idle();
    t_serial();
    t_backpressure();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule